// File: doc/BRIEF.md
# Segmented Converter Result Memory

This block holds the conversion results of an analog-to-digital converter that serves three conversion groups: an event group, group 1 and group 2. A single result RAM is cut into three contiguous segments by two boundary registers. The event group owns the words below the first boundary, group 1 owns the words from the first boundary up to the second, and group 2 owns the rest. Each converter result arrives tagged with a group number and a 5-bit input channel number. It is stored at that group's write position, and the position then advances and wraps inside the segment.

The processor reaches the results over a simple register bus in two ways. Each group has an address window that behaves as a queue. Any read inside the window returns the group's oldest unread result and moves that group's read position forward. The whole RAM is also mapped for direct reads. A direct read returns whatever word sits at the given index, with no empty indication and no effect on any queue. Results in a segment follow the group's conversion order, so software can locate a channel from its offset within the segment. Software can also read each group's absolute write address and compute how many results are valid.

Top module: `adc_seg_mem`

## Requirements
- R1: After reset the first boundary reads 8 and the second reads 16. The write-address registers read 0, 8 and 16. Every group status reads 1, meaning empty.
- R2: When cv_valid is high, a result for group code 0, 1 or 2 is stored at that group's write address, and the address then advances by one. The absolute write address of group g is readable at bus address 0x04+g.
- R3: A result word has the channel in bits 20:16 and the value in bits 11:0, with all other bits zero. When control bit 0 at address 0x02 is set, only value bits 9:0 are kept at the time of writing.
- R4: A read anywhere in the queue window of group g (0x20+16*g to 0x2F+16*g) returns the oldest unread result of that group in write order, and the group's read position then advances.
- R5: A queue read on an empty group returns 0x8000_0000 and leaves that group's read position and status unchanged.
- R6: A read at 0x80+i returns RAM word i in the R3 layout, with no empty flag. A word that was already consumed through a queue still reads back unchanged.
- R7: Direct RAM reads do not change the queue read position of any group.
- R8: The status of group g is at 0x08+g, with bit 0 empty, bit 1 full and bit 2 overrun. A write to a full group is dropped and sets overrun. Overrun then stays set until the group is cleared.
- R9: The write and read positions of a group wrap from the last word of its segment back to the first word of that segment.
- R10: Pulsing grp_clr[g] empties group g. It resets that group's positions and overrun flag and leaves the other groups untouched.
- R11: A bus write to either boundary register, at 0x00 or 0x01, empties all three groups.
- R12: bus_rvalid is high in exactly the cycle after each cycle in which bus_rd is high, and bus_rdata is valid in that cycle.
- R13: A converter result tagged with group code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cv_valid | input | 1 | Converter result strobe |
| cv_group | input | 2 | Group code of the result (0 event, 1, 2) |
| cv_chan | input | 5 | Input channel of the result |
| cv_value | input | 12 | Conversion value |
| grp_clr | input | 3 | Per-group clear pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Register/window address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |

## Verification
A converter write is registered at the clock edge that samples cv_valid, so its effect shows up in any read strobe issued at a later edge. Every read, whether of a register, a queue or the RAM, returns its data exactly one edge after the strobe. The driver pushes the expected word into a scoreboard queue when it raises bus_rd. The monitor pops that word on the falling edge that follows the cycle in which bus_rvalid goes high, and a valid strobe with nothing queued is reported as a timing fault. Stimulus changes only on falling edges, so both the write and the read of a pair always fall on distinct rising edges.

// File: rtl/adcseg_pkg.sv
package adcseg_pkg;
    localparam int CH_W   = 5;
    localparam int VAL_W  = 12;
    localparam int NARROW = 10;
    localparam int WORD_W = 32;
    localparam int NGRP   = 3;

    typedef struct packed {
        logic [CH_W-1:0]  ch;
        logic [VAL_W-1:0] val;
    } rec_t;

    localparam logic [WORD_W-1:0] EMPTY_WORD = 32'h8000_0000;

    localparam logic [7:0] A_BND_A = 8'h00;
    localparam logic [7:0] A_BND_B = 8'h01;
    localparam logic [7:0] A_CTRL  = 8'h02;
    localparam logic [7:0] A_WRP   = 8'h04;
    localparam logic [7:0] A_STAT  = 8'h08;
    localparam int         Q_NIB   = 2;

    function automatic logic [WORD_W-1:0] pack_word(rec_t r);
        return {11'b0, r.ch, 4'b0, r.val};
    endfunction
endpackage

// File: rtl/adcseg_ram.sv
module adcseg_ram #(
    parameter int DEPTH = 32,
    parameter int W     = 17,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem_q[waddr] <= wdata;
        rdata <= mem_q[raddr];
    end
endmodule

// File: rtl/adcseg_grp_ptr.sv
module adcseg_grp_ptr #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic [AW:0]   seg_size,
    input  logic          push_req,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output logic [AW-1:0] wr_off,
    output logic [AW-1:0] rd_off,
    output logic          empty,
    output logic          full,
    output logic          overrun
);
    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
        logic          ovr;
    } st_t;

    st_t st_d, st_q;

    function automatic logic [AW-1:0] step(logic [AW-1:0] p, logic [AW:0] sz);
        return (({1'b0, p} + 1'b1) >= sz) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d    = st_q;
        empty   = (st_q.cnt == '0);
        full    = (st_q.cnt >= seg_size);
        push_ok = push_req && !full && !clr;
        pop_ok  = pop_req && !empty && !clr;
        if (push_ok) st_d.wr = step(st_q.wr, seg_size);
        if (pop_ok)  st_d.rd = step(st_q.rd, seg_size);
        if (push_req && full && !clr) st_d.ovr = 1'b1;
        st_d.cnt = st_q.cnt + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_ok};
        if (clr) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_off  = st_q.wr;
    assign rd_off  = st_q.rd;
    assign overrun = st_q.ovr;

    // R8
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= seg_size);
    // R8
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovr && !clr) |=> st_q.ovr);
    // R5
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop_req && !push_req && !clr) |=> ($stable(st_q.rd) && st_q.cnt == '0));
    // R9
    wrap_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seg_size != '0) |-> ({1'b0, st_q.wr} < seg_size && {1'b0, st_q.rd} < seg_size));
endmodule

// File: rtl/adc_seg_mem.sv
module adc_seg_mem
    import adcseg_pkg::*;
#(
    parameter int DEPTH     = 32,
    parameter int RST_BND_A = 8,
    parameter int RST_BND_B = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cv_valid,
    input  logic [1:0]        cv_group,
    input  logic [CH_W-1:0]   cv_chan,
    input  logic [VAL_W-1:0]  cv_value,
    input  logic [NGRP-1:0]   grp_clr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    output logic [WORD_W-1:0] bus_rdata,
    output logic              bus_rvalid
);
    localparam int AW = $clog2(DEPTH);
    localparam int BW = AW + 1;
    localparam logic [VAL_W-1:0] NARROW_MASK = VAL_W'((1 << NARROW) - 1);

    typedef struct packed {
        logic [BW-1:0]     bnd_a;
        logic [BW-1:0]     bnd_b;
        logic              ten;
        logic              rv;
        logic              rram;
        logic [WORD_W-1:0] rword;
    } st_t;

    st_t st_d, st_q;

    logic [BW-1:0]   seg_base [NGRP];
    logic [BW-1:0]   seg_size [NGRP];
    logic [AW-1:0]   wr_off   [NGRP];
    logic [AW-1:0]   rd_off   [NGRP];
    logic [BW-1:0]   wr_abs   [NGRP];
    logic [BW-1:0]   rd_abs   [NGRP];
    logic [NGRP-1:0] push_req, pop_req, push_ok, pop_ok;
    logic [NGRP-1:0] g_empty, g_full, g_ovr, g_clr, q_hit;
    logic            bnd_wr;
    logic            ram_we;
    logic [AW-1:0]   ram_waddr, ram_raddr;
    rec_t            ram_wdata, ram_rdata;

    always_comb begin
        seg_base[0] = '0;
        seg_size[0] = st_q.bnd_a;
        seg_base[1] = st_q.bnd_a;
        seg_size[1] = (st_q.bnd_b > st_q.bnd_a) ? st_q.bnd_b - st_q.bnd_a : '0;
        seg_base[2] = st_q.bnd_b;
        seg_size[2] = (BW'(DEPTH) > st_q.bnd_b) ? BW'(DEPTH) - st_q.bnd_b : '0;
    end

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        assign wr_abs[g] = seg_base[g] + {1'b0, wr_off[g]};
        assign rd_abs[g] = seg_base[g] + {1'b0, rd_off[g]};
        adcseg_grp_ptr #(.AW(AW)) u_ptr (
            .clk      (clk),
            .rst_n    (rst_n),
            .clr      (g_clr[g]),
            .seg_size (seg_size[g]),
            .push_req (push_req[g]),
            .pop_req  (pop_req[g]),
            .push_ok  (push_ok[g]),
            .pop_ok   (pop_ok[g]),
            .wr_off   (wr_off[g]),
            .rd_off   (rd_off[g]),
            .empty    (g_empty[g]),
            .full     (g_full[g]),
            .overrun  (g_ovr[g])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.rv    = bus_rd;
        st_d.rram  = 1'b0;
        st_d.rword = '0;
        bnd_wr     = bus_wr && (bus_addr == A_BND_A || bus_addr == A_BND_B);
        ram_raddr  = '0;
        ram_waddr  = '0;
        for (int g = 0; g < NGRP; g++) begin
            q_hit[g]    = (bus_addr[7:4] == 4'(Q_NIB + g));
            pop_req[g]  = bus_rd && q_hit[g];
            push_req[g] = cv_valid && (cv_group == 2'(g));
            g_clr[g]    = grp_clr[g] || bnd_wr;
            if (push_ok[g]) ram_waddr = wr_abs[g][AW-1:0];
        end
        ram_we        = |push_ok;
        ram_wdata.ch  = cv_chan;
        ram_wdata.val = st_q.ten ? (cv_value & NARROW_MASK) : cv_value;

        if (bus_wr) begin
            if (bus_addr == A_BND_A) st_d.bnd_a = bus_wdata[BW-1:0];
            if (bus_addr == A_BND_B) st_d.bnd_b = bus_wdata[BW-1:0];
            if (bus_addr == A_CTRL)  st_d.ten   = bus_wdata[0];
        end

        if (bus_rd) begin
            if (bus_addr[7]) begin
                st_d.rram = 1'b1;
                ram_raddr = bus_addr[AW-1:0];
            end else if (|q_hit) begin
                for (int g = 0; g < NGRP; g++) begin
                    if (q_hit[g]) begin
                        if (g_empty[g]) begin
                            st_d.rword = EMPTY_WORD;
                        end else begin
                            st_d.rram = 1'b1;
                            ram_raddr = rd_abs[g][AW-1:0];
                        end
                    end
                end
            end else begin
                if (bus_addr == A_BND_A) st_d.rword = WORD_W'(st_q.bnd_a);
                if (bus_addr == A_BND_B) st_d.rword = WORD_W'(st_q.bnd_b);
                if (bus_addr == A_CTRL)  st_d.rword = WORD_W'(st_q.ten);
                for (int g = 0; g < NGRP; g++) begin
                    if (bus_addr == A_WRP + 8'(g))
                        st_d.rword = WORD_W'(wr_abs[g]);
                    if (bus_addr == A_STAT + 8'(g))
                        st_d.rword = WORD_W'({g_ovr[g], g_full[g], g_empty[g]});
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.bnd_a <= BW'(RST_BND_A);
            st_q.bnd_b <= BW'(RST_BND_B);
        end else begin
            st_q <= st_d;
        end
    end

    adcseg_ram #(.DEPTH(DEPTH), .W($bits(rec_t))) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    assign bus_rvalid = st_q.rv;
    assign bus_rdata  = st_q.rram ? pack_word(ram_rdata) : st_q.rword;

    // R12
    rvalid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    // R12
    rvalid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R13
    bad_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cv_group == 2'd3) |-> !ram_we);
    // R3
    word_layout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> (bus_rdata[30:21] == '0 && bus_rdata[15:12] == '0));
endmodule

// File: tb/adc_seg_mem_tb.sv
module adc_seg_mem_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cv_valid = 1'b0;
    logic [1:0]  cv_group = '0;
    logic [4:0]  cv_chan = '0;
    logic [11:0] cv_value = '0;
    logic [2:0]  grp_clr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_q [$];
    string       tag_q [$];

    always #10 clk = ~clk;

    adc_seg_mem u_dut (
        .clk(clk), .rst_n(rst_n), .cv_valid(cv_valid), .cv_group(cv_group),
        .cv_chan(cv_chan), .cv_value(cv_value), .grp_clr(grp_clr),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    function automatic logic [31:0] w(input int ch, input int val);
        return {11'b0, 5'(ch), 4'b0, 12'(val)};
    endfunction

    task automatic conv(input int g, input int ch, input int val);
        @(negedge clk);
        cv_valid = 1'b1; cv_group = 2'(g); cv_chan = 5'(ch); cv_value = 12'(val);
        @(negedge clk);
        cv_valid = 1'b0;
    endtask

    task automatic bwr(input int a, input int d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 8'(a); bus_wdata = 32'(d);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic brd(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_rd = 1'b1; bus_addr = 8'(a);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic pulse_clr(input logic [2:0] m);
        @(negedge clk);
        grp_clr = m;
        @(negedge clk);
        grp_clr = '0;
    endtask

    // monitor: pops the scoreboard when read data comes back
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            n_run++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL R12 unexpected rvalid: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    n_fail++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        brd(8'h00, 32'd8,  "R1 bnd a");
        brd(8'h01, 32'd16, "R1 bnd b");
        brd(8'h04, 32'd0,  "R1 wrp ev");
        brd(8'h05, 32'd8,  "R1 wrp g1");
        brd(8'h06, 32'd16, "R1 wrp g2");
        brd(8'h08, 32'd1,  "R1 stat ev");
        brd(8'h09, 32'd1,  "R1 stat g1");
        brd(8'h0A, 32'd1,  "R1 stat g2");

        // R2 event writes
        conv(0, 0, 'h111);
        conv(0, 1, 'h222);
        conv(0, 2, 'hABC);
        brd(8'h04, 32'd3, "R2 wrp ev");
        brd(8'h08, 32'd0, "R8 stat nonempty");

        // R4 queue order
        brd(8'h25, w(0, 'h111), "R4 q0");
        brd(8'h2F, w(1, 'h222), "R4 q1");
        brd(8'h20, w(2, 'hABC), "R4 q2");
        // R5 empty queue
        brd(8'h20, 32'h8000_0000, "R5 empty word");
        brd(8'h08, 32'd1, "R5 status empty");

        // R6 direct read of consumed data
        brd(8'h80, w(0, 'h111), "R6 direct 0");
        brd(8'h82, w(2, 'hABC), "R6 direct 2");

        // R7 direct reads leave queue alone
        conv(1, 4, 'h044);
        conv(1, 7, 'h077);
        conv(1, 8, 'h088);
        brd(8'h89, w(7, 'h077), "R7 direct g1");
        brd(8'h88, w(4, 'h044), "R7 direct g1 base");
        brd(8'h30, w(4, 'h044), "R7 queue first");
        brd(8'h3A, w(7, 'h077), "R7 queue second");
        brd(8'h05, 32'd11, "R2 wrp g1");

        // R3 ten-bit mode
        bwr(8'h02, 1);
        conv(2, 3, 'hFFF);
        brd(8'h40, w(3, 'h3FF), "R3 narrow");
        bwr(8'h02, 0);
        conv(2, 5, 'hFFF);
        brd(8'h40, w(5, 'hFFF), "R3 wide");

        // R13 group code 3
        conv(3, 9, 'h123);
        brd(8'h04, 32'd3,  "R13 wrp ev");
        brd(8'h05, 32'd11, "R13 wrp g1");
        brd(8'h06, 32'd18, "R13 wrp g2");
        brd(8'h21, 32'h8000_0000, "R13 ev still empty");

        // R10 per-group clear
        pulse_clr(3'b010);
        brd(8'h05, 32'd8, "R10 wrp g1");
        brd(8'h09, 32'd1, "R10 stat g1");
        brd(8'h30, 32'h8000_0000, "R10 g1 drained");
        brd(8'h04, 32'd3,  "R10 ev untouched");
        brd(8'h06, 32'd18, "R10 g2 untouched");

        // R11 boundary write clears all
        bwr(8'h00, 4);
        bwr(8'h01, 6);
        brd(8'h04, 32'd0, "R11 wrp ev");
        brd(8'h05, 32'd4, "R11 wrp g1");
        brd(8'h06, 32'd6, "R11 wrp g2");
        brd(8'h08, 32'd1, "R11 stat ev");
        brd(8'h0A, 32'd1, "R11 stat g2");

        // R8 full and overrun, segment of two words
        conv(1, 1, 'h101);
        conv(1, 2, 'h102);
        conv(1, 3, 'h103);
        brd(8'h09, 32'd6, "R8 full overrun");
        brd(8'h05, 32'd4, "R9 wrp wrapped");
        brd(8'h30, w(1, 'h101), "R8 q first");
        brd(8'h30, w(2, 'h102), "R8 third dropped");
        brd(8'h30, 32'h8000_0000, "R8 drained");
        brd(8'h09, 32'd5, "R8 overrun sticky");

        // R9 wrap of read and write positions
        conv(1, 6, 'h106);
        brd(8'h84, w(6, 'h106), "R9 stored at base");
        brd(8'h05, 32'd5, "R9 wrp after wrap");
        brd(8'h30, w(6, 'h106), "R9 read wrapped");

        repeat (4) @(negedge clk);
        n_run++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL R12 missing rvalid: actual %0d pending expected 0", exp_q.size());
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule